// File: doc/BRIEF.md
# Ninety-Pin GPIO Direction and Level Unit

This block is a memory-mapped general-purpose I/O unit for ninety pins. Software reads the pin levels through three read-only level words and decides, pin by pin, whether each pin is driven, through three read/write direction words. Each pin owns one bit in one level word and one bit in one direction word. Pins 0 to 31 use bits 31:0 of the first word of each kind, pins 32 to 63 use the second word, and pins 64 to 89 use bits 25:0 of the third.

Pad inputs pass through a two-flop synchronizer, and the synchronizer's second stage is the level register. A level read therefore shows a pin change two clocks after it occurs. Each pad output enable follows its direction bit combinationally. For pins 0 to 85 a direction bit of 1 means drive. For the top four pins, 86 to 89, the sense is reversed: after reset those four pins drive and every other pin listens.

The bus side is a single-cycle register port. A write takes effect on the clock edge where write enable is high. Read data follows the address combinationally.

Top module: `pinbank_gpio`

## Requirements
- R1: Byte offsets 0x00, 0x04 and 0x08 read the synchronized level of pins 0–31, 32–63 and 64–89. Pin p appears at bit p mod 32 of word p div 32, and a high pin reads as 1.
- R2: Byte offsets 0x0C, 0x10 and 0x14 are the direction words, with the same bit mapping as R1. A write there is stored on the write edge and reads back unchanged, except for the reserved bits of R6.
- R3: For pins 0 to 85, pad_oe[p] equals the pin's direction bit, so 1 drives the pin.
- R4: For pins 86 to 89, pad_oe[p] is the inverse of the pin's direction bit, so 0 drives the pin.
- R5: While rst_n is low, and after it is released, every direction bit is 0 and every level bit is 0. pad_oe is therefore 0 for pins 0–85 and 1 for pins 86–89.
- R6: Bits 31:26 at offsets 0x08 and 0x14 always read 0, and writes to those bits are discarded.
- R7: A pad change that is present at a clock edge first shows in a level read after the second following edge, counting that edge.
- R8: A write to offsets 0x00, 0x04 or 0x08 changes no direction bit and no output enable.
- R9: Offsets 0x18 and 0x1C read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Byte address; bits 1:0 are ignored |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| pad_in | input | 90 | Pad input levels |
| pad_oe | output | 90 | Pad output enables |

## Verification
The bench first targets the polarity boundary between pin 85 and pin 86 by writing all ones and then all zeros to the third direction word. A design that carried the inversion to the wrong pins, or left it out, would show enables flipped on pins 85 to 89. Reserved-bit writes and reads with every pad high would expose a design that stores or reports bits 31:26 of the third words. A reset in the middle of the run must restore the four driven top pins. Level reads taken one edge and two edges after a pad change catch a synchronizer that is one stage short or one stage long. Writes to the level words and the unmapped words, each followed by a direction readback, catch decoding that aliases those offsets onto the direction registers.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;
   localparam int unsigned WORD_W = 32;

   // Bits of word w that hold a real pin when npins pins are packed.
   function automatic logic [WORD_W-1:0] live_mask(int unsigned w, int unsigned npins);
      logic [WORD_W-1:0] m;
      m = '0;
      for (int unsigned b = 0; b < WORD_W; b++) begin
         if (w * WORD_W + b < npins) m[b] = 1'b1;
      end
      return m;
   endfunction
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
   parameter int unsigned W = 90
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stage1_q;
   logic [W-1:0] stage2_q;
   logic [1:0]   warm_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage1_q <= '0;
         stage2_q <= '0;
      end else begin
         stage1_q <= d;
         stage2_q <= stage1_q;
      end
   end

   // Counts edges since reset so the lag check never looks before reset.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               warm_q <= 2'd0;
      else if (warm_q != 2'd2)  warm_q <= warm_q + 2'd1;
   end

   assign q = stage2_q;

   assert_level_lag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (warm_q == 2'd2) |-> (q == $past(d, 2)));
endmodule

// File: rtl/dir_bank.sv
module dir_bank
   import pinbank_pkg::*;
#(
   parameter int unsigned NUM_PINS  = 90,
   parameter int unsigned INV_FIRST = 86,
   parameter int unsigned NUM_WORDS = 3,
   parameter int unsigned IDX_W     = 3
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [IDX_W-1:0]              wr_word,
   input  logic [WORD_W-1:0]             wr_data,
   output logic [NUM_WORDS*WORD_W-1:0]   dir_flat,
   output logic [NUM_PINS-1:0]           oe
);
   logic [NUM_WORDS-1:0][WORD_W-1:0] dir_q;

   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      localparam logic [WORD_W-1:0] MASK = live_mask(w, NUM_PINS);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            dir_q[w] <= '0;
         else if (wr_en && wr_word == IDX_W'(w))
            dir_q[w] <= wr_data & MASK;
      end

      assert_dir_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && wr_word == IDX_W'(w)) |=> (dir_q[w] == ($past(wr_data) & MASK)));

      assert_resv_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (dir_q[w] & ~MASK) == '0);
   end

   assign dir_flat = dir_q;

   // Output enable polarity: straight below INV_FIRST, inverted from it up.
   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      if (p >= INV_FIRST) begin : g_inv
         assign oe[p] = ~dir_flat[p];
      end else begin : g_str
         assign oe[p] = dir_flat[p];
      end
   end
endmodule

// File: rtl/reg_read.sv
module reg_read
   import pinbank_pkg::*;
#(
   parameter int unsigned NUM_WORDS = 3,
   parameter int unsigned IDX_W     = 3
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [IDX_W-1:0]            idx,
   input  logic [NUM_WORDS*WORD_W-1:0] level_flat,
   input  logic [NUM_WORDS*WORD_W-1:0] dir_flat,
   output logic [WORD_W-1:0]           rdata
);
   localparam int unsigned MAPPED = 2 * NUM_WORDS;

   always_comb begin
      rdata = '0;
      if (int'(idx) < NUM_WORDS)
         rdata = level_flat[int'(idx) * WORD_W +: WORD_W];
      else if (int'(idx) < MAPPED)
         rdata = dir_flat[(int'(idx) - NUM_WORDS) * WORD_W +: WORD_W];
   end

   assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(idx) >= MAPPED) |-> (rdata == '0));
endmodule

// File: rtl/pinbank_gpio.sv
module pinbank_gpio
   import pinbank_pkg::*;
#(
   parameter int unsigned NUM_PINS  = 90,
   parameter int unsigned INV_FIRST = 86,
   parameter int unsigned ADDR_W    = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic                 bus_we,
   input  logic [WORD_W-1:0]    bus_wdata,
   output logic [WORD_W-1:0]    bus_rdata,
   input  logic [NUM_PINS-1:0]  pad_in,
   output logic [NUM_PINS-1:0]  pad_oe
);
   localparam int unsigned NUM_WORDS = (NUM_PINS + WORD_W - 1) / WORD_W;
   localparam int unsigned IDX_W     = ADDR_W - 2;

   if (NUM_PINS < 1) begin : g_err_pins
      $error("pinbank_gpio: NUM_PINS must be at least 1");
   end
   if (INV_FIRST > NUM_PINS) begin : g_err_inv
      $error("pinbank_gpio: INV_FIRST beyond NUM_PINS");
   end
   if (ADDR_W < 3 || 2 * NUM_WORDS > (1 << IDX_W)) begin : g_err_addr
      $error("pinbank_gpio: ADDR_W too small for the register map");
   end

   logic [IDX_W-1:0]              word_idx;
   logic                          unused_lsb;
   logic                          dir_hit;
   logic [IDX_W-1:0]              dir_word;
   logic [NUM_PINS-1:0]           level_q;
   logic [NUM_WORDS*WORD_W-1:0]   level_flat;
   logic [NUM_WORDS*WORD_W-1:0]   dir_flat;

   assign word_idx   = bus_addr[ADDR_W-1:2];
   assign unused_lsb = ^bus_addr[1:0];
   assign dir_hit    = (int'(word_idx) >= NUM_WORDS) && (int'(word_idx) < 2 * NUM_WORDS);
   assign dir_word   = word_idx - IDX_W'(NUM_WORDS);
   assign level_flat = (NUM_WORDS*WORD_W)'(level_q);

   pin_sync #(.W(NUM_PINS)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (level_q)
   );

   dir_bank #(
      .NUM_PINS  (NUM_PINS),
      .INV_FIRST (INV_FIRST),
      .NUM_WORDS (NUM_WORDS),
      .IDX_W     (IDX_W)
   ) u_dir (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (bus_we && dir_hit),
      .wr_word  (dir_word),
      .wr_data  (bus_wdata),
      .dir_flat (dir_flat),
      .oe       (pad_oe)
   );

   reg_read #(
      .NUM_WORDS (NUM_WORDS),
      .IDX_W     (IDX_W)
   ) u_rd (
      .clk        (clk),
      .rst_n      (rst_n),
      .idx        (word_idx),
      .level_flat (level_flat),
      .dir_flat   (dir_flat),
      .rdata      (bus_rdata)
   );

   // R8 and R9: only a direction offset may alter enables.
   assert_oe_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_we && dir_hit) |=> $stable(pad_oe));
endmodule

// File: tb/pinbank_gpio_tb_top.sv
module pinbank_gpio_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NP = 90;
   localparam int INV = 86;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [NP-1:0] pad_in = '0;
   logic [NP-1:0] pad_oe;

   int checks = 0;
   int fails = 0;
   string phase = "R5";
   bit done = 0;

   // Behavioural reference state
   bit ref_dir [96];
   bit sync1 [NP];
   bit sync2 [NP];

   always #(CLK_PERIOD/2) clk = ~clk;

   pinbank_gpio dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_oe(pad_oe)
   );

   task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_rd(logic [4:0] a);
      int w;
      logic [31:0] r;
      w = int'(a >> 2);
      r = '0;
      for (int b = 0; b < 32; b++) begin
         if (w < 3) begin
            if (w * 32 + b < NP) r[b] = sync2[w * 32 + b];
         end else if (w < 6) begin
            r[b] = ref_dir[(w - 3) * 32 + b];
         end
      end
      return r;
   endfunction

   function automatic logic [NP-1:0] exp_oe();
      logic [NP-1:0] e;
      for (int p = 0; p < NP; p++) e[p] = (p >= INV) ? !ref_dir[p] : ref_dir[p];
      return e;
   endfunction

   task automatic model_clear();
      for (int i = 0; i < 96; i++) ref_dir[i] = 0;
      for (int p = 0; p < NP; p++) begin sync1[p] = 0; sync2[p] = 0; end
   endtask

   // One clock: update the model at the edge, compare at the falling edge.
   task automatic step();
      int w;
      @(posedge clk);
      if (!rst_n) model_clear();
      else begin
         if (bus_we) begin
            w = int'(bus_addr >> 2);
            if (w >= 3 && w < 6)
               for (int b = 0; b < 32; b++)
                  ref_dir[(w - 3) * 32 + b] = ((w - 3) * 32 + b < NP) ? bus_wdata[b] : 1'b0;
         end
         for (int p = 0; p < NP; p++) begin sync2[p] = sync1[p]; sync1[p] = pad_in[p]; end
      end
      @(negedge clk);
      chk({phase, " oe"}, 128'(pad_oe), 128'(exp_oe()));
      chk({phase, " rdata"}, 128'(bus_rdata), 128'(exp_rd(bus_addr)));
   endtask

   task automatic wr(logic [4:0] a, logic [31:0] d);
      bus_addr = a; bus_we = 1'b1; bus_wdata = d;
      step();
      bus_we = 1'b0;
   endtask

   task automatic rd(logic [4:0] a);
      bus_addr = a;
      step();
   endtask

   initial begin
      logic [NP-1:0] pat;
      logic [NP-1:0] oe_before;
      model_clear();
      repeat (3) step();
      // R5: enables and reads during reset
      chk("R5 oe in reset", 128'(pad_oe), 128'({4'hF, 86'b0}));
      @(negedge clk) rst_n = 1'b1;
      chk("R5 oe after reset", 128'(pad_oe), 128'({4'hF, 86'b0}));
      for (int a = 0; a < 24; a += 4) begin
         rd(5'(a));
         chk("R5 read zero", 128'(bus_rdata), 128'(0));
      end

      // R7 and R1: two-edge lag and pin-to-bit mapping
      phase = "R7";
      pat = 90'h2A5_1234_5678_9ABC_DEF0_1357;
      bus_addr = 5'h00; pad_in = pat;
      step();
      chk("R7 one edge old", 128'(bus_rdata), 128'(0));
      step();
      chk("R7 two edges new", 128'(bus_rdata), 128'(pat[31:0]));
      phase = "R1";
      rd(5'h04); chk("R1 word1", 128'(bus_rdata), 128'(pat[63:32]));
      rd(5'h08); chk("R1 word2", 128'(bus_rdata), 128'({6'b0, pat[89:64]}));

      // R6: all pads high, reserved level bits stay zero
      phase = "R6";
      pad_in = '1;
      step(); step();
      rd(5'h08); chk("R6 level resv", 128'(bus_rdata), 128'(32'h03FF_FFFF));

      // R2, R3, R4: direction storage and polarity
      phase = "R2";
      wr(5'h0C, 32'hA5A5_0F0F);
      rd(5'h0C); chk("R2 dir0 readback", 128'(bus_rdata), 128'(32'hA5A5_0F0F));
      chk("R3 oe low pins", 128'(pad_oe[31:0]), 128'(32'hA5A5_0F0F));
      wr(5'h10, 32'hFFFF_0000);
      chk("R3 oe mid pins", 128'(pad_oe[63:32]), 128'(32'hFFFF_0000));
      wr(5'h14, 32'hFFFF_FFFF);
      rd(5'h14); chk("R6 dir resv", 128'(bus_rdata), 128'(32'h03FF_FFFF));
      chk("R3 oe pins 64-85", 128'(pad_oe[85:64]), 128'(22'h3F_FFFF));
      chk("R4 oe top off", 128'(pad_oe[89:86]), 128'(4'h0));
      wr(5'h14, 32'h0000_0000);
      chk("R4 oe top on", 128'(pad_oe[89:86]), 128'(4'hF));
      chk("R3 oe pin 85 off", 128'(pad_oe[85]), 128'(0));

      // R8: writes to level offsets
      phase = "R8";
      oe_before = pad_oe;
      wr(5'h00, 32'hFFFF_FFFF);
      wr(5'h04, 32'h0000_0000);
      wr(5'h08, 32'hFFFF_FFFF);
      chk("R8 oe unchanged", 128'(pad_oe), 128'(oe_before));
      rd(5'h10); chk("R8 dir1 unchanged", 128'(bus_rdata), 128'(32'hFFFF_0000));

      // R9: unmapped offsets
      phase = "R9";
      rd(5'h18); chk("R9 read 0x18", 128'(bus_rdata), 128'(0));
      wr(5'h1C, 32'h0000_FFFF);
      rd(5'h1C); chk("R9 read 0x1C", 128'(bus_rdata), 128'(0));
      rd(5'h0C); chk("R9 dir0 unchanged", 128'(bus_rdata), 128'(32'hA5A5_0F0F));

      // R1/R2 mixed traffic compared every clock
      phase = "R1";
      for (int i = 0; i < 300; i++) begin
         bus_addr  = 5'($urandom_range(0, 31));
         bus_we    = 1'($urandom);
         bus_wdata = $urandom;
         pad_in    = NP'({$urandom, $urandom, $urandom});
         step();
      end
      bus_we = 1'b0;

      // R5: reset in mid-run
      phase = "R5";
      wr(5'h14, 32'h03FF_FFFF);
      @(negedge clk) rst_n = 1'b0;
      #1 chk("R5 async reset oe", 128'(pad_oe), 128'({4'hF, 86'b0}));
      step(); step();
      @(negedge clk) rst_n = 1'b1;
      rd(5'h14); chk("R5 dir2 cleared", 128'(bus_rdata), 128'(0));

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog expired phase=%s actual=hung expected=done", phase);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule